// File: doc/BRIEF.md
# Field and Line Sequencer

This block keeps track of where a television raster stands, line by line and field by field, and turns that position into the vertical-rate gating windows that a line-rate pulse generator needs. It advances on two strobes from that generator. One marks the start of each line and the other marks the middle of each line. From the count it derives four things. The first is which half-lines carry equalizing or serration pulses instead of the normal line sync. The second and third are the vertical blanking window and the vertical drive window. The fourth is the set of whole-line windows for burst suppression, the white-measurement line and the identification line.

Three static inputs configure the block. One selects a 625-line or 525-line standard. One removes a line from each frame, which gives 624 or 524 lines and an identical pair of fields with no interlace. A 3-bit system code picks the blanking length and the colour-system behaviour. A lock controller can restart the frame at line 1, or ask for the current frame to be one line longer or one line shorter so that the raster slips toward an external frame phase.

Top module: `fld_line_seq`

## Requirements
- R1: After reset, `line_num` is 1, `second_half` is 0 and `frame_odd` is 0. Each `line_stb` advances `line_num` by one and clears `second_half`. A `half_stb` that arrives without `line_stb` sets `second_half`. A `line_stb` on the last line of the frame returns `line_num` to 1.
- R2: The nominal frame length is 625 lines when `std525`=0 and 525 lines when `std525`=1. `short_frame`=1 lowers it by one line, to 624 or 524. `frame_odd` toggles each time the frame wraps to line 1.
- R3: The half-line index is h = 2*(line_num-1) + second_half, and N is the nominal frame length. `field2` is 1 exactly when h >= N, so with an odd N the second field starts in the middle of a line.
- R4: Within a field the relative index is r = h (field 1) or r = h-N (field 2). P is 5 half-lines for 625 and 6 half-lines for 525. `eq_gate` is 1 for r in [0,P) and for r in [2P,3P). `serr_gate` is 1 for r in [P,2P).
- R5: `vblank` is 1 for r < 2K. K is 25 for system codes 0 (PAL), 3 (PAL-M), 4 (SECAM1), 5 (SECAM2), 6 and 7. K is 21 for code 1 (NTSC1) and 19 for code 2 (NTSC2).
- R6: `vdrive` is 1 for r < 20 in 625-line operation and for r < 12 in 525-line operation.
- R7: In 625-line operation with a non-SECAM code, `burst_sup` covers lines >=623 or <=6, and lines 310..318, when `frame_odd`=0 or `short_frame`=1. It covers lines >=622 or <=5, and lines 311..319, when `frame_odd`=1 and `short_frame`=0. SECAM codes 4 and 5 never assert `burst_sup`.
- R8: In 525-line operation with a non-SECAM code, `burst_sup` covers lines >=523 or <=6, and lines 261..269, in every frame.
- R9: `wmp_win` covers lines 163..173 and 475..485 for 625, and lines 134..143 and 396..405 for 525.
- R10: `id_win` covers lines 7..15 and 320..328, and only for system code 4 (SECAM1).
- R11: An `add_line` pulse lengthens the current frame by one line, and a `drop_line` pulse shortens it by one line. A request must come before the frame's last line. When both are pending they cancel. Pending requests clear when the frame wraps, so the next frame has its nominal length again.
- R12: `frame_rst` sets line 1, `second_half`=0 and `frame_odd`=0, and it discards pending add or drop requests. It takes priority over a strobe in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| line_stb | input | 1 | One-cycle strobe at each line start |
| half_stb | input | 1 | One-cycle strobe at mid-line |
| std525 | input | 1 | 1 selects 525-line, 0 selects 625-line timing |
| short_frame | input | 1 | 1 removes one line per frame, non-interlaced |
| sys_sel | input | 3 | Colour system code (see R5) |
| frame_rst | input | 1 | Restart at line 1 of field 1 |
| add_line | input | 1 | Lengthen current frame by one line |
| drop_line | input | 1 | Shorten current frame by one line |
| line_num | output | LW | Current line, 1-based |
| second_half | output | 1 | Second half of the current line |
| frame_odd | output | 1 | Alternates each frame |
| field2 | output | 1 | Position lies in the second field |
| eq_gate | output | 1 | Half-line carries equalizing pulses |
| serr_gate | output | 1 | Half-line carries serration pulses |
| vblank | output | 1 | Vertical blanking window |
| vdrive | output | 1 | Vertical drive window |
| burst_sup | output | 1 | Burst suppressed on this line |
| wmp_win | output | 1 | White-measurement line window |
| id_win | output | 1 | Identification line window |

## Verification
The bench walks whole frame pairs under eight combinations of standard, line reduction and system code. At every half-line it compares all outputs against an independent model. This catches a field boundary that lands on a whole line instead of a half line, off-by-one edges on the equalizing and serration trains, and a burst table that fails to alternate or that alternates in the non-interlaced mode. Directed tests measure frame lengths after add, drop and combined requests, and check that a request does not carry into the following frame, which a design that failed to clear it would do. They also send a frame restart in the same cycle as a line strobe and after a pending request, where a wrong priority or an uncleared request would show as a non-unit line or a wrong next frame length.

// File: rtl/fsq_pkg.sv
package fsq_pkg;
   typedef enum logic [2:0] {
      SYS_PAL    = 3'd0,
      SYS_NTSC1  = 3'd1,
      SYS_NTSC2  = 3'd2,
      SYS_PALM   = 3'd3,
      SYS_SECAM1 = 3'd4,
      SYS_SECAM2 = 3'd5,
      SYS_RSV6   = 3'd6,
      SYS_RSV7   = 3'd7
   } sys_e;

   function automatic logic in_span(input int v, input int lo, input int hi);
      return (v >= lo) && (v <= hi);
   endfunction

   function automatic logic is_secam(input sys_e s);
      return (s == SYS_SECAM1) || (s == SYS_SECAM2);
   endfunction
endpackage

// File: rtl/fsq_line_ctr.sv
module fsq_line_ctr #(
   parameter int LW   = 10,
   parameter int L625 = 625,
   parameter int L525 = 525
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          line_stb,
   input  logic          half_stb,
   input  logic          frame_rst,
   input  logic          add_line,
   input  logic          drop_line,
   input  logic          std525,
   input  logic          short_frame,
   output logic [LW-1:0] line_q,
   output logic          half_q,
   output logic          odd_q,
   output logic [LW-1:0] nlines
);
   logic pend_add, pend_drop;
   int   nom_i, end_i;

   always_comb begin
      nom_i  = (std525 ? L525 : L625) - int'(short_frame);
      end_i  = nom_i + int'(pend_add) - int'(pend_drop);
      nlines = LW'(nom_i);
   end

   always_ff @(posedge clk) begin
      if (!rst_n || frame_rst) begin
         line_q    <= LW'(1);
         half_q    <= 1'b0;
         odd_q     <= 1'b0;
         pend_add  <= 1'b0;
         pend_drop <= 1'b0;
      end else begin
         if (add_line)  pend_add  <= 1'b1;
         if (drop_line) pend_drop <= 1'b1;
         if (line_stb) begin
            half_q <= 1'b0;
            if (int'(line_q) >= end_i) begin
               line_q    <= LW'(1);
               odd_q     <= ~odd_q;
               pend_add  <= add_line;
               pend_drop <= drop_line;
            end else begin
               line_q <= line_q + LW'(1);
            end
         end else if (half_stb) begin
            half_q <= 1'b1;
         end
      end
   end

   p_line_nonzero_r1: assert property (@(posedge clk) disable iff (!rst_n)
      line_q != '0);
   p_wrap_to_one_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (line_stb && !frame_rst && int'(line_q) >= end_i) |=> (line_q == LW'(1)));
   p_odd_toggles_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (!frame_rst && line_q != LW'(1) && $past(line_q) != LW'(1) && $past(rst_n)) |-> $stable(odd_q));
   p_restart_r12: assert property (@(posedge clk) disable iff (!rst_n)
      frame_rst |=> (line_q == LW'(1) && !half_q && !odd_q));
endmodule

// File: rtl/fsq_vsync.sv
module fsq_vsync
   import fsq_pkg::*;
#(
   parameter int LW     = 10,
   parameter int EQ625  = 5,
   parameter int EQ525  = 6,
   parameter int VD625  = 10,
   parameter int VD525  = 6,
   parameter int VB_STD = 25,
   parameter int VB_N1  = 21,
   parameter int VB_N2  = 19
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [LW-1:0] line_q,
   input  logic          half_q,
   input  logic [LW-1:0] nlines,
   input  logic          std525,
   input  sys_e          sys,
   output logic          field2,
   output logic          eq_gate,
   output logic          serr_gate,
   output logic          vblank,
   output logic          vdrive
);
   localparam int VB_MIN = (VB_N2 < VB_N1) ? VB_N2 : VB_N1;

   if (3 * EQ625 > 2 * VB_MIN || 3 * EQ525 > 2 * VB_MIN)
      $error("equalizing block longer than vertical blanking");
   if (VD625 > VB_MIN || VD525 > VB_MIN)
      $error("vertical drive longer than vertical blanking");

   int h_i, r_i, p_i, k_i, d_i;

   always_comb begin
      h_i    = 2 * (int'(line_q) - 1) + int'(half_q);
      field2 = h_i >= int'(nlines);
      r_i    = field2 ? h_i - int'(nlines) : h_i;
      p_i    = std525 ? EQ525 : EQ625;
      d_i    = 2 * (std525 ? VD525 : VD625);
      unique case (sys)
         SYS_NTSC1: k_i = 2 * VB_N1;
         SYS_NTSC2: k_i = 2 * VB_N2;
         default:   k_i = 2 * VB_STD;
      endcase
      eq_gate   = (r_i < p_i) || (r_i >= 2 * p_i && r_i < 3 * p_i);
      serr_gate = (r_i >= p_i) && (r_i < 2 * p_i);
      vblank    = r_i < k_i;
      vdrive    = r_i < d_i;
   end

   p_eq_serr_excl_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !(eq_gate && serr_gate));
   p_serr_in_blank_r5: assert property (@(posedge clk) disable iff (!rst_n)
      serr_gate |-> vblank);
   p_vdrive_in_blank_r6: assert property (@(posedge clk) disable iff (!rst_n)
      vdrive |-> vblank);
endmodule

// File: rtl/fsq_windows.sv
module fsq_windows
   import fsq_pkg::*;
#(
   parameter int LW = 10
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [LW-1:0] line_q,
   input  logic          odd_q,
   input  logic          std525,
   input  logic          short_frame,
   input  sys_e          sys,
   output logic          burst_sup,
   output logic          wmp_win,
   output logic          id_win
);
   int ln;
   logic b625_even, b625_odd, b525;

   always_comb begin
      ln        = int'(line_q);
      b625_even = ln >= 623 || ln <= 6 || in_span(ln, 310, 318);
      b625_odd  = ln >= 622 || ln <= 5 || in_span(ln, 311, 319);
      b525      = ln >= 523 || ln <= 6 || in_span(ln, 261, 269);
      if (is_secam(sys))
         burst_sup = 1'b0;
      else if (std525)
         burst_sup = b525;
      else
         burst_sup = (odd_q && !short_frame) ? b625_odd : b625_even;
      wmp_win = std525 ? (in_span(ln, 134, 143) || in_span(ln, 396, 405))
                       : (in_span(ln, 163, 173) || in_span(ln, 475, 485));
      id_win  = (sys == SYS_SECAM1) && (in_span(ln, 7, 15) || in_span(ln, 320, 328));
   end

   p_secam_no_burst_r7: assert property (@(posedge clk) disable iff (!rst_n)
      is_secam(sys) |-> !burst_sup);
   p_wmp_clear_of_burst_r9: assert property (@(posedge clk) disable iff (!rst_n)
      wmp_win |-> !burst_sup);
   p_id_secam1_only_r10: assert property (@(posedge clk) disable iff (!rst_n)
      id_win |-> (sys == SYS_SECAM1));
endmodule

// File: rtl/fld_line_seq.sv
module fld_line_seq
   import fsq_pkg::*;
#(
   parameter int LW   = 10,
   parameter int L625 = 625,
   parameter int L525 = 525
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          line_stb,
   input  logic          half_stb,
   input  logic          std525,
   input  logic          short_frame,
   input  logic [2:0]    sys_sel,
   input  logic          frame_rst,
   input  logic          add_line,
   input  logic          drop_line,
   output logic [LW-1:0] line_num,
   output logic          second_half,
   output logic          frame_odd,
   output logic          field2,
   output logic          eq_gate,
   output logic          serr_gate,
   output logic          vblank,
   output logic          vdrive,
   output logic          burst_sup,
   output logic          wmp_win,
   output logic          id_win
);
   if (L525 >= L625 || L525 < 400)
      $error("line counts out of range");
   if ((1 << LW) <= L625 + 1)
      $error("LW too narrow for the longest frame");

   sys_e          sys;
   logic [LW-1:0] nlines;

   assign sys = sys_e'(sys_sel);

   fsq_line_ctr #(.LW(LW), .L625(L625), .L525(L525)) u_ctr (
      .clk(clk), .rst_n(rst_n), .line_stb(line_stb), .half_stb(half_stb),
      .frame_rst(frame_rst), .add_line(add_line), .drop_line(drop_line),
      .std525(std525), .short_frame(short_frame),
      .line_q(line_num), .half_q(second_half), .odd_q(frame_odd), .nlines(nlines)
   );

   fsq_vsync #(.LW(LW)) u_vs (
      .clk(clk), .rst_n(rst_n), .line_q(line_num), .half_q(second_half),
      .nlines(nlines), .std525(std525), .sys(sys),
      .field2(field2), .eq_gate(eq_gate), .serr_gate(serr_gate),
      .vblank(vblank), .vdrive(vdrive)
   );

   fsq_windows #(.LW(LW)) u_win (
      .clk(clk), .rst_n(rst_n), .line_q(line_num), .odd_q(frame_odd),
      .std525(std525), .short_frame(short_frame), .sys(sys),
      .burst_sup(burst_sup), .wmp_win(wmp_win), .id_win(id_win)
   );

   p_field2_half_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (line_num == LW'(1) && !second_half) |-> !field2);
endmodule

// File: tb/test_fld_line_seq.sv
module test_fld_line_seq;
   logic       clk = 1'b0, rst_n = 1'b0, line_stb = 1'b0, half_stb = 1'b0;
   logic       std525 = 1'b0, short_frame = 1'b0, frame_rst = 1'b0;
   logic       add_line = 1'b0, drop_line = 1'b0;
   logic [2:0] sys_sel = 3'd0;
   logic [9:0] line_num;
   logic second_half, frame_odd, field2, eq_gate, serr_gate, vblank, vdrive;
   logic burst_sup, wmp_win, id_win;

   fld_line_seq i_fld_line_seq (
      .clk(clk), .rst_n(rst_n), .line_stb(line_stb), .half_stb(half_stb),
      .std525(std525), .short_frame(short_frame), .sys_sel(sys_sel),
      .frame_rst(frame_rst), .add_line(add_line), .drop_line(drop_line),
      .line_num(line_num), .second_half(second_half), .frame_odd(frame_odd),
      .field2(field2), .eq_gate(eq_gate), .serr_gate(serr_gate), .vblank(vblank),
      .vdrive(vdrive), .burst_sup(burst_sup), .wmp_win(wmp_win), .id_win(id_win)
   );

   always #10 clk = ~clk;

   int checks = 0, errors = 0;
   int mL = 1, mH = 0, mOdd = 0;
   logic [10:0] seen;

   // config word: [4] std525, [3] short_frame, [2:0] system code
   localparam logic [4:0] CFG [8] = '{
      5'b0_0_000, 5'b1_0_001, 5'b1_0_010, 5'b0_0_100,
      5'b0_1_101, 5'b1_1_011, 5'b0_0_110, 5'b1_0_011 };

   function automatic int nom();
      return (std525 ? 525 : 625) - int'(short_frame);
   endfunction

   task automatic check(input logic ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic compare_all();
      int n, h, r, p, k, d, e;
      logic [10:0] ex, ac;
      string tags [11];
      tags = '{"R1 line_num", "R1 second_half", "R2 frame_odd", "R3 field2",
               "R4 eq_gate", "R4 serr_gate", "R5 vblank", "R6 vdrive",
               std525 ? "R8 burst_sup" : "R7 burst_sup", "R9 wmp_win", "R10 id_win"};
      n = nom();
      h = 2 * (mL - 1) + mH;
      r = (h >= n) ? h - n : h;
      p = std525 ? 6 : 5;
      k = (sys_sel == 3'd1) ? 42 : (sys_sel == 3'd2) ? 38 : 50;
      d = std525 ? 12 : 20;
      ex[0] = 1'b1;
      ex[1] = mH[0];
      ex[2] = mOdd[0];
      ex[3] = h >= n;
      ex[4] = (r < p) || (r >= 2*p && r < 3*p);
      ex[5] = (r >= p) && (r < 2*p);
      ex[6] = r < k;
      ex[7] = r < d;
      if (sys_sel == 3'd4 || sys_sel == 3'd5) ex[8] = 1'b0;
      else if (std525) ex[8] = mL >= 523 || mL <= 6 || (mL >= 261 && mL <= 269);
      else if (mOdd == 0 || short_frame) ex[8] = mL >= 623 || mL <= 6 || (mL >= 310 && mL <= 318);
      else ex[8] = mL >= 622 || mL <= 5 || (mL >= 311 && mL <= 319);
      ex[9] = std525 ? ((mL >= 134 && mL <= 143) || (mL >= 396 && mL <= 405))
                     : ((mL >= 163 && mL <= 173) || (mL >= 475 && mL <= 485));
      ex[10] = (sys_sel == 3'd4) && ((mL >= 7 && mL <= 15) || (mL >= 320 && mL <= 328));
      ac = {id_win, wmp_win, burst_sup, vdrive, vblank, serr_gate, eq_gate,
            field2, frame_odd, second_half, int'(line_num) == mL};
      for (int i = 0; i < 11; i++) begin
         if (ac[i] !== ex[i] && !seen[i]) begin
            seen[i] = 1'b1;
            e = (i == 0) ? mL : int'(ex[i]);
            $display("FAIL %s at line %0d half %0d: actual=%0d expected=%0d",
                     tags[i], mL, mH, (i == 0) ? int'(line_num) : int'(ac[i]), e);
         end
      end
   endtask

   task automatic pulse_frst();
      @(negedge clk) frame_rst = 1'b1;
      @(negedge clk) frame_rst = 1'b0;
      mL = 1; mH = 0; mOdd = 0;
   endtask

   task automatic strobe_line();
      @(negedge clk) line_stb = 1'b1;
      @(negedge clk) line_stb = 1'b0;
   endtask

   task automatic strobe_half();
      @(negedge clk) half_stb = 1'b1;
      @(negedge clk) half_stb = 1'b0;
   endtask

   task automatic pulse_req(input logic add, input logic drop);
      @(negedge clk) begin add_line = add; drop_line = drop; end
      @(negedge clk) begin add_line = 1'b0; drop_line = 1'b0; end
   endtask

   task automatic frame_len(output int c);
      c = 0;
      do begin strobe_line(); c++; end while (line_num != 10'd1 && c < 800);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: run did not complete");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      int len;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state, plus gates at the first half-line (R4, R5)
      check(line_num == 10'd1, "R1 reset line_num", int'(line_num), 1);
      check(!second_half && !frame_odd, "R1 reset half/odd", int'({second_half, frame_odd}), 0);
      check(eq_gate && !serr_gate, "R4 reset eq_gate", int'({eq_gate, serr_gate}), 2);
      check(vblank && vdrive, "R5 reset vblank/vdrive", int'({vblank, vdrive}), 3);

      // table-driven: two full frames per configuration, every half-line compared
      for (int c = 0; c < 8; c++) begin
         @(negedge clk);
         std525 = CFG[c][4]; short_frame = CFG[c][3]; sys_sel = CFG[c][2:0];
         pulse_frst();
         seen = '0;
         compare_all();
         for (int s = 0; s < 4 * nom(); s++) begin
            if (s % 2 == 0) begin
               strobe_half(); mH = 1;
            end else begin
               strobe_line(); mH = 0;
               if (mL >= nom()) begin mL = 1; mOdd ^= 1; end else mL++;
            end
            compare_all();
         end
         for (int i = 0; i < 11; i++) begin
            checks++;
            if (seen[i]) errors++;
         end
      end

      // R11 frame length adjustments, 625-line standard
      @(negedge clk); std525 = 1'b0; short_frame = 1'b0; sys_sel = 3'd0;
      pulse_frst(); pulse_req(1'b1, 1'b0); frame_len(len);
      check(len == 626, "R11 add-line frame length", len, 626);
      frame_len(len);
      check(len == 625, "R11 request cleared at wrap", len, 625);
      pulse_req(1'b0, 1'b1); frame_len(len);
      check(len == 624, "R11 drop-line frame length", len, 624);
      pulse_req(1'b1, 1'b1); frame_len(len);
      check(len == 625, "R11 add and drop cancel", len, 625);
      @(negedge clk); std525 = 1'b1; short_frame = 1'b1;
      pulse_frst(); pulse_req(1'b1, 1'b0); frame_len(len);
      check(len == 525, "R11 add-line on 524-line frame", len, 525);
      // R2 reduced frame length
      frame_len(len);
      check(len == 524, "R2 reduced 525-line frame", len, 524);

      // R12 restart in same cycle as line strobe, mid second frame
      @(negedge clk); std525 = 1'b0; short_frame = 1'b0;
      pulse_frst(); frame_len(len);
      for (int i = 0; i < 100; i++) strobe_line();
      strobe_half();
      @(negedge clk) begin frame_rst = 1'b1; line_stb = 1'b1; end
      @(negedge clk) begin frame_rst = 1'b0; line_stb = 1'b0; end
      check(line_num == 10'd1, "R12 restart line_num", int'(line_num), 1);
      check(!second_half && !frame_odd, "R12 restart half/odd", int'({second_half, frame_odd}), 0);
      // R12 restart discards a pending request
      pulse_req(1'b1, 1'b0); pulse_frst(); frame_len(len);
      check(len == 625, "R12 restart clears pending add", len, 625);

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule